// File: doc/BRIEF.md
# Diode Switch Matrix Scanner

This block reads a front-panel switch matrix of ten rows by five columns. A diode sits in series with each switch. The block pulls one row line low at a time, waits for the column lines to settle, and then reads the five columns one after another. When it has read every row, it has a 50-bit picture of which switches are closed. It publishes that picture and compares it with the previous one. If they differ, it pulses a change flag so the processor knows to rescan its controls.

The block does not run freely. A periodic tick from the system interrupt divider paces it, and a full scan starts on every tenth tick. Column inputs come from the panel without a clock relationship, so they pass through a two-flop synchronizer before use. A settle wait after each row change covers both the panel wiring and that synchronizer. Some intersections of the matrix have no switch. A parameter mask marks those positions, and the image always shows them as open.

Top module: `swmatrix_scan`

## Requirements
- R1: While reset is asserted and just after it is released, every row output is high, the image output is all zeros and the change flag is low.
- R2: No more than one row output is low in any cycle.
- R3: The block counts every tick, including ticks that arrive during a scan.
  - A scan begins only at the clock edge that samples the tenth tick since reset, and then every tenth tick after that.
  - A tick that completes a count of ten while a scan is running is ignored, and no scan is queued for it.
- R4: Let edge T be the edge that starts a scan.
  - Row r (0 to 9) is the only low row from edge T+8r until edge T+8r+8. This is three wait cycles followed by five column samples.
  - At edge T+80, all rows return high.
- R5: Image bit r*5+c is 1 when column c reads low while row r is driven low, and 0 otherwise. Any position whose bit in the present-switch mask is 0 reads 0 whatever the column shows.
- R6: The image output changes only at the edge that ends a scan. Between scans it holds its value.
- R7: At the end of a scan, the change flag goes high for exactly one cycle, but only if the new image differs from the image published before it. The image before the first scan counts as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Periodic tick, one cycle wide |
| col_i | input | 5 | Column lines; low means a closed switch on the driven row |
| row_n_o | output | 10 | Row drives, active low |
| image_o | output | 50 | Published switch image, bit r*5+c, 1 = closed |
| changed_o | output | 1 | One-cycle pulse when the new image differs from the last |

## Verification
The hardest situation to reach from the ports is a tick count that reaches ten while a scan is still running. Ticks normally arrive far apart, so this never happens on its own. To force it, the stimulus sends ten back-to-back ticks in the middle of a scan. It then checks three things:
- the current scan finishes on its normal schedule;
- the rows stay high afterwards;
- the next scan needs a fresh set of ten ticks.

A single closed switch is also walked through all fifty positions, including the two masked ones. This exercises every image bit and the change flag in both directions.

// File: rtl/swscan_pkg.sv
package swscan_pkg;

    typedef enum logic [1:0] {
        SC_IDLE   = 2'd0,
        SC_WAIT   = 2'd1,
        SC_SAMPLE = 2'd2
    } scan_state_e;

endpackage

// File: rtl/swscan_colsync.sv
module swscan_colsync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    assign stg_d[0] = d_i;

    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        assign stg_d[s] = stg_q[s-1];
    end

    // Columns idle high (open), so reset to ones.
    for (genvar s = 0; s < STAGES; s++) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[s] <= '1;
            else         stg_q[s] <= stg_d[s];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/swscan_tickdiv.sv
module swscan_tickdiv #(
    parameter int TICK_DIV = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic busy_i,
    output logic start_o
);

    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t div_d, div_q;
    logic wrap;

    assign wrap = tick_i && (div_q.cnt == LAST);

    always_comb begin
        div_d = div_q;
        if (tick_i) begin
            div_d.cnt = (div_q.cnt == LAST) ? '0 : div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end

    // A wrap that lands during a scan is dropped, not queued.
    assign start_o = wrap && !busy_i;

endmodule

// File: rtl/swscan_seq.sv
module swscan_seq
    import swscan_pkg::*;
#(
    parameter int N_ROWS      = 10,
    parameter int N_COLS      = 5,
    parameter int SETTLE_CYC  = 1,
    parameter int SYNC_STAGES = 2,
    parameter logic [N_ROWS*N_COLS-1:0] PRESENT_MASK = '1
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       start_i,
    input  logic [N_COLS-1:0]          col_i,
    output logic                       busy_o,
    output logic [N_ROWS-1:0]          row_n_o,
    output logic [N_ROWS*N_COLS-1:0]   image_o,
    output logic                       changed_o
);

    localparam int NSW      = N_ROWS * N_COLS;
    localparam int RW       = $clog2(N_ROWS + 1);
    localparam int CLW      = (N_COLS > 1) ? $clog2(N_COLS) : 1;
    localparam int IW       = $clog2(NSW);
    localparam int WAIT_CYC = SETTLE_CYC + SYNC_STAGES;
    localparam int WW       = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1;

    localparam logic [RW-1:0]     ROW_LAST = RW'(N_ROWS - 1);
    localparam logic [CLW-1:0]    COL_LAST = CLW'(N_COLS - 1);
    localparam logic [WW-1:0]     WAIT_LD  = WW'(WAIT_CYC - 1);
    localparam logic [N_ROWS-1:0] ROW_ONE  = N_ROWS'(1);

    typedef struct packed {
        scan_state_e     state;
        logic [RW-1:0]   row;
        logic [CLW-1:0]  col;
        logic [WW-1:0]   wcnt;
        logic [N_ROWS-1:0] row_n;
        logic [NSW-1:0]  work;
        logic [NSW-1:0]  image;
        logic            changed;
    } seq_t;

    seq_t sq_d, sq_q;
    logic [IW-1:0] bit_idx;

    assign bit_idx = IW'(sq_q.row) * IW'(N_COLS) + IW'(sq_q.col);

    always_comb begin
        sq_d         = sq_q;
        sq_d.changed = 1'b0;
        unique case (sq_q.state)
            SC_IDLE: begin
                if (start_i) begin
                    sq_d.state = SC_WAIT;
                    sq_d.row   = '0;
                    sq_d.col   = '0;
                    sq_d.wcnt  = WAIT_LD;
                    sq_d.row_n = ~ROW_ONE;
                    sq_d.work  = '0;
                end
            end
            SC_WAIT: begin
                // Covers panel settling plus synchronizer latency.
                if (sq_q.wcnt == '0) sq_d.state = SC_SAMPLE;
                else                 sq_d.wcnt  = sq_q.wcnt - 1'b1;
            end
            SC_SAMPLE: begin
                sq_d.work[bit_idx] = PRESENT_MASK[bit_idx] & ~col_i[sq_q.col];
                if (sq_q.col == COL_LAST) begin
                    sq_d.col = '0;
                    if (sq_q.row == ROW_LAST) begin
                        sq_d.state   = SC_IDLE;
                        sq_d.row_n   = '1;
                        sq_d.image   = sq_d.work;
                        sq_d.changed = (sq_d.work != sq_q.image);
                    end else begin
                        sq_d.state = SC_WAIT;
                        sq_d.row   = sq_q.row + 1'b1;
                        sq_d.wcnt  = WAIT_LD;
                        sq_d.row_n = ~(ROW_ONE << (sq_q.row + 1'b1));
                    end
                end else begin
                    sq_d.col = sq_q.col + 1'b1;
                end
            end
            default: begin
                sq_d.state = SC_IDLE;
                sq_d.row_n = '1;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sq_q       <= '0;
            sq_q.state <= SC_IDLE;
            sq_q.row_n <= '1;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy_o    = (sq_q.state != SC_IDLE);
    assign row_n_o   = sq_q.row_n;
    assign image_o   = sq_q.image;
    assign changed_o = sq_q.changed;

endmodule

// File: rtl/swmatrix_scan.sv
module swmatrix_scan #(
    parameter int N_ROWS      = 10,
    parameter int N_COLS      = 5,
    parameter int TICK_DIV    = 10,
    parameter int SETTLE_CYC  = 1,
    parameter int SYNC_STAGES = 2,
    parameter logic [N_ROWS*N_COLS-1:0] PRESENT_MASK = 50'h3_DFFF_FFFF_FFEF
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     tick_i,
    input  logic [N_COLS-1:0]        col_i,
    output logic [N_ROWS-1:0]        row_n_o,
    output logic [N_ROWS*N_COLS-1:0] image_o,
    output logic                     changed_o
);

    logic [N_COLS-1:0] col_sync;
    logic              start;
    logic              busy;

    swscan_colsync #(
        .WIDTH  (N_COLS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (col_i),
        .q_o    (col_sync)
    );

    swscan_tickdiv #(
        .TICK_DIV (TICK_DIV)
    ) u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .busy_i  (busy),
        .start_o (start)
    );

    swscan_seq #(
        .N_ROWS       (N_ROWS),
        .N_COLS       (N_COLS),
        .SETTLE_CYC   (SETTLE_CYC),
        .SYNC_STAGES  (SYNC_STAGES),
        .PRESENT_MASK (PRESENT_MASK)
    ) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start),
        .col_i     (col_sync),
        .busy_o    (busy),
        .row_n_o   (row_n_o),
        .image_o   (image_o),
        .changed_o (changed_o)
    );

endmodule

// File: rtl/swmatrix_scan_chk.sv
module swmatrix_scan_chk #(
    parameter int N_ROWS = 10,
    parameter int N_COLS = 5,
    parameter logic [N_ROWS*N_COLS-1:0] PRESENT_MASK = '1
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     tick_i,
    input logic [N_ROWS-1:0]        row_n_o,
    input logic [N_ROWS*N_COLS-1:0] image_o,
    input logic                     changed_o
);

    AST_ONE_ROW_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(~row_n_o) <= 1); // R2

    AST_START_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(&row_n_o) |-> $past(tick_i)); // R3

    AST_END_AFTER_LAST_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(&row_n_o) |-> !$past(row_n_o[N_ROWS-1])); // R4

    AST_ABSENT_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (image_o & ~PRESENT_MASK) == '0); // R5

    AST_IMAGE_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(image_o) |-> ($rose(&row_n_o) && changed_o)); // R6

    AST_CHANGE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        changed_o |=> !changed_o); // R7

    AST_CHANGE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        changed_o |-> $rose(&row_n_o)); // R7

endmodule

bind swmatrix_scan swmatrix_scan_chk #(
    .N_ROWS       (N_ROWS),
    .N_COLS       (N_COLS),
    .PRESENT_MASK (PRESENT_MASK)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .row_n_o   (row_n_o),
    .image_o   (image_o),
    .changed_o (changed_o)
);

// File: tb/sim_swmatrix_scan.sv
module sim_swmatrix_scan;

    localparam int NR  = 10;
    localparam int NC  = 5;
    localparam int NSW = NR * NC;
    localparam logic [NSW-1:0] MASK    = 50'h3_DFFF_FFFF_FFEF;
    localparam logic [NR-1:0]  ROW_ONE = NR'(1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tick = 1'b0;
    logic [NC-1:0]   col;
    logic [NR-1:0]   row_n;
    logic [NSW-1:0]  image;
    logic            changed;
    logic [NSW-1:0]  sw = '0;
    logic [NSW-1:0]  prev_exp = '0;
    int              n_chk = 0;
    int              n_fail = 0;
    bit              done = 1'b0;

    always #10 clk = ~clk;

    swmatrix_scan #(
        .N_ROWS       (NR),
        .N_COLS       (NC),
        .TICK_DIV     (10),
        .SETTLE_CYC   (1),
        .SYNC_STAGES  (2),
        .PRESENT_MASK (MASK)
    ) u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .col_i     (col),
        .row_n_o   (row_n),
        .image_o   (image),
        .changed_o (changed)
    );

    // Panel model: a closed switch on a low row pulls its column low.
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            col[c] = 1'b1;
            for (int r = 0; r < NR; r++) begin
                if (!row_n[r] && sw[r*NC+c]) col[c] = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run_scan(input logic [NSW-1:0] pat, input bit flood);
        logic [NSW-1:0] exp_img;
        logic [NR-1:0]  exp_row;
        exp_img = pat & MASK;
        sw = pat;
        for (int t = 0; t < 9; t++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            check(row_n == '1, "R3 no scan before tenth tick", 64'(row_n), 64'({NR{1'b1}}));
        end
        @(negedge clk) tick = 1'b1;
        @(posedge clk);
        @(negedge clk) tick = 1'b0;
        for (int k = 0; k < 80; k++) begin
            if (k > 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            exp_row = ~(ROW_ONE << (k / 8));
            check(row_n == exp_row, "R4 row order", 64'(row_n), 64'(exp_row));
            check(image == prev_exp, "R6 image held during scan", 64'(image), 64'(prev_exp));
            tick = (flood && k >= 10 && k < 20);
        end
        @(posedge clk);
        @(negedge clk);
        check(row_n == '1, "R4 rows high at end", 64'(row_n), 64'({NR{1'b1}}));
        check(image == exp_img, "R5 image", 64'(image), 64'(exp_img));
        check(changed == (exp_img != prev_exp), "R7 change flag", 64'(changed),
              64'(exp_img != prev_exp));
        @(posedge clk);
        @(negedge clk);
        check(changed == 1'b0, "R7 one-cycle pulse", 64'(changed), 64'd0);
        check(image == exp_img, "R6 image holds", 64'(image), 64'(exp_img));
        if (flood) begin
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                check(row_n == '1, "R3 wrap during scan ignored", 64'(row_n), 64'({NR{1'b1}}));
            end
        end
        prev_exp = exp_img;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(row_n == '1, "R1 rows in reset", 64'(row_n), 64'({NR{1'b1}}));
        check(image == '0, "R1 image in reset", 64'(image), 64'd0);
        check(changed == 1'b0, "R1 flag in reset", 64'(changed), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(row_n == '1, "R1 rows after reset", 64'(row_n), 64'({NR{1'b1}}));
        check(image == '0 && changed == 1'b0, "R1 outputs after reset",
              64'(image), 64'd0);

        run_scan('0, 1'b0);
        for (int i = 0; i < NSW; i++) run_scan(NSW'(1) << i, 1'b0);
        run_scan('1, 1'b0);
        run_scan('1, 1'b1);
        run_scan(50'h1_5555_5555_5555, 1'b0);
        run_scan(50'h2_AAAA_AAAA_AAAA, 1'b1);
        run_scan(~MASK, 1'b0);
        run_scan(~MASK, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule